// File: doc/BRIEF.md
# OUT Packet Commit Controller

This block stands between a pool of receive packet buffers and the byte FIFO of an OUT endpoint. Each time a buffer finishes filling, the pool reports the buffer's index and byte count. The block places that report in a small ring of pending buffers and keeps the original order. It then handles the oldest pending buffer in one of two ways. In auto mode, hardware commits the buffer to the FIFO with no controller involved. In manual mode, the block raises an interrupt and waits. A controller then decides whether the packet goes into the FIFO or is thrown away.

The FIFO side is tracked as a byte level. Commits add the packet's count to the level, and the `fifo_rd` strobe removes one byte per cycle. The level and its empty and full flags change on the same edge as the commit. Auto mode is reached only through a fixed arming order: revision control on, then a FIFO flush, then every pending buffer disposed of by command, and only then the auto request. Until that order completes, the block stays in manual operation.

There are two state machines. The arming sequencer has five states: `AS_OFF`, `AS_REV`, `AS_FLUSHED`, `AS_ARMED` and `AS_AUTO`. Its transitions are:
- OFF→REV when `rev_en` is high.
- REV→FLUSHED on `fifo_flush`.
- FLUSHED→ARMED once the ring is empty.
- ARMED→AUTO when `auto_req` is high.
- AUTO→ARMED when `auto_req` drops.
- Any state→OFF when `rev_en` is low.

The commit machine has three states: `CS_IDLE`, `CS_HOLD` and `CS_STALL`. Its transitions are:
- IDLE→HOLD when a buffer is pending in manual mode.
- IDLE→STALL when a buffer is pending in auto mode but will not fit.
- IDLE stays IDLE after an auto commit.
- STALL→IDLE when the stalled commit is made.
- STALL→HOLD if auto mode ends.
- HOLD→IDLE on an accepted skip, on an accepted commit, or when auto mode takes over.

Top module: `out_commit_ctrl`

## Requirements
- R1: After reset the level is 0, `fifo_empty` is 1, and `fifo_full`, `irq`, `cmd_err`, `auto_on` and `commit_valid` are all 0.
- R2: While `auto_on` is 1, a buffer captured on edge k whose count fits is committed on edge k+1. `commit_valid` pulses with that buffer's index and count, and `irq` stays low.
- R3: The level rises by the committed count on the same edge as the `commit_valid` pulse and falls by one for each `fifo_rd` cycle. A read at level 0 is ignored. `fifo_empty` means a level of 0, `fifo_full` means a level equal to FIFO_CAP, and a `fifo_flush` cycle sets the level to 0.
- R4: In manual mode, a buffer captured on edge k raises `irq` from edge k+1. It is not committed while no command arrives.
- R5: In manual mode, a `cmd_strobe` with `cmd_skip`=0 commits the held buffer. The commit pulse and the level change appear on the accepting edge. With `cmd_skip`=1 the buffer is discarded, with no commit pulse and no level change. `irq` drops on the accepting edge.
- R6: Buffers are committed or discarded strictly in the order in which they filled, in both modes.
- R7: `auto_on` rises only after this order: `rev_en` high, then a `fifo_flush`, then an empty ring, then `auto_req` high. `auto_req` given earlier in the order has no effect, and dropping `rev_en` returns the block to manual operation.
- R8: A `cmd_strobe` while no buffer is held for a command (the commit machine is not in HOLD, or the strobe falls in a flush cycle) changes nothing and sets the sticky `cmd_err` bit. Only reset clears `cmd_err`.
- R9: A commit never pushes the level above FIFO_CAP. An auto commit waits until the head count fits. A manual commit that does not fit is refused: the buffer stays held, `irq` stays high and `cmd_err` is set.
- R10: No commit takes place in a `fifo_flush` cycle. A pending auto commit happens on the edge after the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A buffer has finished filling |
| fill_idx | input | IDX_W | Index of the filled buffer |
| fill_count | input | CNT_W | Byte count of the filled buffer |
| auto_req | input | 1 | Request for hardware auto-commit |
| rev_en | input | 1 | Revision-control enable, first step of arming |
| fifo_flush | input | 1 | FIFO reset; clears the level |
| cmd_strobe | input | 1 | Controller command strobe |
| cmd_skip | input | 1 | With the strobe: 1 discards, 0 commits |
| fifo_rd | input | 1 | One byte read out of the FIFO |
| commit_valid | output | 1 | One-cycle pulse: a buffer was committed |
| commit_idx | output | IDX_W | Index of the committed buffer |
| commit_count | output | CNT_W | Byte count of the committed buffer |
| fifo_level | output | LVL_W | Bytes held in the FIFO |
| fifo_empty | output | 1 | Level is zero |
| fifo_full | output | 1 | Level equals FIFO_CAP |
| irq | output | 1 | Endpoint interrupt: a buffer awaits a command |
| cmd_err | output | 1 | Sticky: a strobe was stray or refused |
| auto_on | output | 1 | Auto-commit mode is active |

## Verification
A commit and a byte read can land on the same edge. The bench provokes this by holding `fifo_rd` high in the very cycle an auto commit takes place, and judges the level against the previous level plus the count minus one. A flush can also collide with a due auto commit. That is provoked by raising `fifo_flush` in the cycle after the fill is captured. The bench then expects no pulse and a zero level on that edge, and the commit with the full count one edge later.

// File: rtl/out_commit_pkg.sv
package out_commit_pkg;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_HOLD,
        CS_STALL
    } cmt_state_t;

    typedef enum logic [2:0] {
        AS_OFF,
        AS_REV,
        AS_FLUSHED,
        AS_ARMED,
        AS_AUTO
    } arm_state_t;

endpackage

// File: rtl/commit_ring.sv
module commit_ring #(
    parameter int NBUF  = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [CNT_W-1:0] push_cnt,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] head_cnt,
    output logic             nonempty
);

    localparam int PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int OCC_W = $clog2(NBUF + 1);

    logic [IDX_W-1:0] slot_idx [NBUF];
    logic [CNT_W-1:0] slot_cnt [NBUF];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;
    logic             push_ok, pop_ok;

    assign push_ok  = push && (occ != OCC_W'(NBUF));
    assign pop_ok   = pop && (occ != '0);
    assign nonempty = (occ != '0);
    assign head_idx = slot_idx[rd_ptr];
    assign head_cnt = slot_cnt[rd_ptr];

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PTR_W'(g)) begin
                slot_idx[g] <= push_idx;
                slot_cnt[g] <= push_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(NBUF - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(NBUF - 1)) ? '0 : rd_ptr + PTR_W'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   occ <= occ + OCC_W'(1);
                2'b01:   occ <= occ - OCC_W'(1);
                default: occ <= occ;
            endcase
        end
    end

endmodule

// File: rtl/fifo_level_track.sv
module fifo_level_track #(
    parameter int FIFO_CAP = 2048,
    parameter int CNT_W    = 10,
    parameter int LVL_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_cnt,
    input  logic             rd,
    input  logic [CNT_W-1:0] probe_cnt,
    output logic             fits,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    localparam int SW = LVL_W + 1;

    logic [SW-1:0]    probe_sum;
    logic [LVL_W-1:0] lvl_nx;

    assign probe_sum = {1'b0, level} + SW'(probe_cnt);
    assign fits      = (probe_sum <= SW'(FIFO_CAP));
    assign empty     = (level == '0);
    assign full      = (level == LVL_W'(FIFO_CAP));

    always_comb begin
        lvl_nx = level;
        if (add_en)
            lvl_nx = lvl_nx + LVL_W'(add_cnt);
        if (rd && level != '0)
            lvl_nx = lvl_nx - LVL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            level <= '0;
        else
            level <= lvl_nx;
    end

endmodule

// File: rtl/auto_arm_seq.sv
module auto_arm_seq
    import out_commit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rev_en,
    input  logic flush,
    input  logic ring_empty,
    input  logic auto_req,
    output logic auto_on
);

    arm_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        if (!rev_en) begin
            st_nx = AS_OFF;
        end else begin
            unique case (st)
                AS_OFF:     st_nx = AS_REV;
                AS_REV:     if (flush) st_nx = AS_FLUSHED;
                AS_FLUSHED: if (ring_empty) st_nx = AS_ARMED;
                AS_ARMED:   if (auto_req) st_nx = AS_AUTO;
                AS_AUTO:    if (!auto_req) st_nx = AS_ARMED;
                default:    st_nx = AS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= AS_OFF;
        else
            st <= st_nx;
    end

    always_comb begin
        auto_on = (st == AS_AUTO);
    end

endmodule

// File: rtl/out_commit_ctrl.sv
module out_commit_ctrl
    import out_commit_pkg::*;
#(
    parameter int NBUF     = 4,
    parameter int PKT_MAX  = 512,
    parameter int FIFO_CAP = 2048,
    parameter int IDX_W    = (NBUF > 1) ? $clog2(NBUF) : 1,
    parameter int CNT_W    = $clog2(PKT_MAX + 1),
    parameter int LVL_W    = $clog2(FIFO_CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [CNT_W-1:0] fill_count,
    input  logic             auto_req,
    input  logic             rev_en,
    input  logic             fifo_flush,
    input  logic             cmd_strobe,
    input  logic             cmd_skip,
    input  logic             fifo_rd,
    output logic             commit_valid,
    output logic [IDX_W-1:0] commit_idx,
    output logic [CNT_W-1:0] commit_count,
    output logic [LVL_W-1:0] fifo_level,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             irq,
    output logic             cmd_err,
    output logic             auto_on
);

    cmt_state_t       st, st_nx;
    logic [IDX_W-1:0] head_idx;
    logic [CNT_W-1:0] head_cnt;
    logic             ring_ne, fits;
    logic             do_auto, acc_commit, acc_skip, refused, stray;
    logic             commit_now, pop_now;

    assign commit_now = do_auto | acc_commit;
    assign pop_now    = commit_now | acc_skip;

    commit_ring #(
        .NBUF (NBUF),
        .IDX_W(IDX_W),
        .CNT_W(CNT_W)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (fill_valid),
        .push_idx(fill_idx),
        .push_cnt(fill_count),
        .pop     (pop_now),
        .head_idx(head_idx),
        .head_cnt(head_cnt),
        .nonempty(ring_ne)
    );

    fifo_level_track #(
        .FIFO_CAP(FIFO_CAP),
        .CNT_W   (CNT_W),
        .LVL_W   (LVL_W)
    ) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (fifo_flush),
        .add_en   (commit_now),
        .add_cnt  (head_cnt),
        .rd       (fifo_rd),
        .probe_cnt(head_cnt),
        .fits     (fits),
        .level    (fifo_level),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    auto_arm_seq u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rev_en    (rev_en),
        .flush     (fifo_flush),
        .ring_empty(!ring_ne),
        .auto_req  (auto_req),
        .auto_on   (auto_on)
    );

    // Next-state and decision logic for the commit machine
    always_comb begin
        st_nx      = st;
        do_auto    = 1'b0;
        acc_commit = 1'b0;
        acc_skip   = 1'b0;
        refused    = 1'b0;
        stray      = cmd_strobe && (st != CS_HOLD || fifo_flush);
        unique case (st)
            CS_IDLE: begin
                if (ring_ne && !fifo_flush) begin
                    if (!auto_on)
                        st_nx = CS_HOLD;
                    else if (fits)
                        do_auto = 1'b1;
                    else
                        st_nx = CS_STALL;
                end
            end
            CS_STALL: begin
                if (!auto_on) begin
                    st_nx = CS_HOLD;
                end else if (fits && !fifo_flush) begin
                    do_auto = 1'b1;
                    st_nx   = CS_IDLE;
                end
            end
            CS_HOLD: begin
                if (cmd_strobe && !fifo_flush) begin
                    if (cmd_skip) begin
                        acc_skip = 1'b1;
                        st_nx    = CS_IDLE;
                    end else if (fits) begin
                        acc_commit = 1'b1;
                        st_nx      = CS_IDLE;
                    end else begin
                        refused = 1'b1;
                    end
                end else if (auto_on) begin
                    st_nx = CS_IDLE;
                end
            end
            default: st_nx = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= CS_IDLE;
        else
            st <= st_nx;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid <= 1'b0;
            commit_idx   <= '0;
            commit_count <= '0;
            cmd_err      <= 1'b0;
        end else begin
            commit_valid <= commit_now;
            if (commit_now) begin
                commit_idx   <= head_idx;
                commit_count <= head_cnt;
            end
            if (stray || refused)
                cmd_err <= 1'b1;
        end
    end

    always_comb begin
        irq = (st == CS_HOLD);
    end

endmodule

// File: rtl/out_commit_chk.sv
module out_commit_chk #(
    parameter int FIFO_CAP = 2048,
    parameter int CNT_W    = 10,
    parameter int LVL_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_flush,
    input logic             fifo_rd,
    input logic             cmd_strobe,
    input logic             cmd_skip,
    input logic             auto_req,
    input logic             rev_en,
    input logic             commit_valid,
    input logic [CNT_W-1:0] commit_count,
    input logic [LVL_W-1:0] fifo_level,
    input logic             irq,
    input logic             cmd_err,
    input logic             auto_on
);

    assert_irq_leaves_auto_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && irq && !cmd_strobe) |=> !irq);

    assert_level_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= FIFO_CAP);

    assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fifo_flush) |->
        int'(fifo_level) == int'($past(fifo_level))
            + (commit_valid ? int'(commit_count) : 0)
            - (($past(fifo_rd) && $past(fifo_level) != '0) ? 1 : 0));

    assert_flush_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (fifo_level == '0 && !commit_valid));

    assert_commit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> ($past(auto_on) || $past(cmd_strobe && !cmd_skip)));

    assert_skip_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cmd_strobe && cmd_skip && !fifo_flush) |=> !irq);

    assert_skip_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_skip && !auto_on) |=> !commit_valid);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    assert_auto_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_on) |-> $past(auto_req && rev_en));

endmodule

bind out_commit_ctrl out_commit_chk #(
    .FIFO_CAP(FIFO_CAP),
    .CNT_W   (CNT_W),
    .LVL_W   (LVL_W)
) u_chk (.*);

// File: tb/tb_out_commit_ctrl.sv
module tb_out_commit_ctrl;

    localparam int NBUF  = 4;
    localparam int PMAX  = 16;
    localparam int CAP   = 40;
    localparam int IDX_W = 2;
    localparam int CNT_W = 5;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fill_valid = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic [CNT_W-1:0] fill_count = '0;
    logic             auto_req = 1'b0, rev_en = 1'b0, fifo_flush = 1'b0;
    logic             cmd_strobe = 1'b0, cmd_skip = 1'b0, fifo_rd = 1'b0;
    logic             commit_valid;
    logic [IDX_W-1:0] commit_idx;
    logic [CNT_W-1:0] commit_count;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_empty, fifo_full, irq, cmd_err, auto_on;

    int checks = 0;
    int errors = 0;
    int lvl = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    out_commit_ctrl #(.NBUF(NBUF), .PKT_MAX(PMAX), .FIFO_CAP(CAP)) dut (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int idx, input int cnt);
        fill_valid = 1'b1;
        fill_idx   = IDX_W'(idx);
        fill_count = CNT_W'(cnt);
    endtask

    task automatic drain();
        while (lvl > 0) begin
            fifo_rd = 1'b1;
            step();
            lvl--;
            chk(int'(fifo_level) == lvl, "R3 read step", int'(fifo_level), lvl);
        end
        fifo_rd = 1'b0;
        chk(fifo_empty == 1'b1, "R3 empty flag", fifo_empty, 1);
    endtask

    // manual: fill, wait for irq, then command
    task automatic manual_one(input int idx, input int cnt, input bit skip);
        fill(idx, cnt);
        step();
        fill_valid = 1'b0;
        step();
        chk(irq == 1'b1, "R4 irq raised", irq, 1);
        cmd_strobe = 1'b1;
        cmd_skip   = skip;
        step();
        cmd_strobe = 1'b0;
        cmd_skip   = 1'b0;
        chk(irq == 1'b0, "R5 irq cleared", irq, 0);
        chk(commit_valid == !skip, "R5 commit pulse", commit_valid, !skip);
        if (!skip) begin
            lvl += cnt;
            chk(int'(commit_count) == cnt, "R5 count", int'(commit_count), cnt);
            chk(int'(commit_idx) == idx, "R5 idx", int'(commit_idx), idx);
        end
        chk(int'(fifo_level) == lvl, "R3 level after command", int'(fifo_level), lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        chk(fifo_level == '0, "R1 level", int'(fifo_level), 0);
        chk(fifo_empty && !fifo_full, "R1 flags", {fifo_empty, fifo_full}, 2);
        chk(!irq && !cmd_err && !auto_on && !commit_valid, "R1 outputs",
            {irq, cmd_err, auto_on, commit_valid}, 0);

        // R4 R5 R3 manual sweep over counts and skip choice
        for (int c = 1; c <= PMAX; c++) begin
            for (int s = 0; s < 2; s++) begin
                fill(c % NBUF, c);
                step();
                fill_valid = 1'b0;
                chk(irq == 1'b0, "R4 irq not yet", irq, 0);
                step();
                step();
                chk(irq == 1'b1, "R4 irq held", irq, 1);
                chk(commit_valid == 1'b0, "R4 no commit without command", commit_valid, 0);
                cmd_strobe = 1'b1;
                cmd_skip   = s[0];
                step();
                cmd_strobe = 1'b0;
                chk(irq == 1'b0, "R5 irq drop", irq, 0);
                chk(commit_valid == (s == 0), "R5 skip choice", commit_valid, s == 0);
                if (s == 0) begin
                    lvl += c;
                    chk(int'(commit_count) == c, "R5 count", int'(commit_count), c);
                end
                chk(int'(fifo_level) == lvl, "R3 level", int'(fifo_level), lvl);
                drain();
            end
        end

        // R8 stray strobe
        chk(cmd_err == 1'b0, "R8 err clear", cmd_err, 0);
        cmd_strobe = 1'b1;
        step();
        cmd_strobe = 1'b0;
        chk(commit_valid == 1'b0 && fifo_level == '0, "R8 stray ignored", commit_valid, 0);
        chk(cmd_err == 1'b1, "R8 err set", cmd_err, 1);
        repeat (3) step();
        chk(cmd_err == 1'b1, "R8 err sticky", cmd_err, 1);

        // R9 manual refused when full
        manual_one(0, 16, 0);
        manual_one(1, 16, 0);
        manual_one(2, 8, 0);
        chk(fifo_full == 1'b1, "R3 full flag", fifo_full, 1);
        fill(3, 1);
        step();
        fill_valid = 1'b0;
        step();
        cmd_strobe = 1'b1;
        step();
        cmd_strobe = 1'b0;
        chk(commit_valid == 1'b0, "R9 refused", commit_valid, 0);
        chk(irq == 1'b1, "R9 still held", irq, 1);
        chk(int'(fifo_level) == CAP, "R9 level kept", int'(fifo_level), CAP);
        fifo_rd = 1'b1;
        step();
        fifo_rd = 1'b0;
        lvl--;
        cmd_strobe = 1'b1;
        step();
        cmd_strobe = 1'b0;
        lvl++;
        chk(commit_valid && commit_idx == 2'd3, "R9 commit after room", int'(commit_idx), 3);
        chk(int'(fifo_level) == lvl, "R9 level", int'(fifo_level), lvl);
        fifo_flush = 1'b1;
        step();
        fifo_flush = 1'b0;
        lvl = 0;
        chk(fifo_level == '0, "R3 flush zero", int'(fifo_level), 0);

        // R6 order with a skip in the middle
        fill(1, 5); step();
        fill(2, 6); step();
        fill(3, 7); step();
        fill_valid = 1'b0;
        step();
        for (int k = 1; k <= 3; k++) begin
            cmd_strobe = 1'b1;
            cmd_skip   = (k == 2);
            step();
            cmd_strobe = 1'b0;
            cmd_skip   = 1'b0;
            if (k != 2) begin
                lvl += k + 4;
                chk(commit_valid && int'(commit_idx) == k, "R6 order", int'(commit_idx), k);
            end else begin
                chk(commit_valid == 1'b0, "R6 skipped slot", commit_valid, 0);
            end
            step();
        end
        chk(int'(fifo_level) == lvl, "R6 level", int'(fifo_level), lvl);
        drain();

        // R7 arming order
        auto_req = 1'b1;
        repeat (3) step();
        chk(auto_on == 1'b0, "R7 no rev", auto_on, 0);
        rev_en = 1'b1;
        repeat (3) step();
        chk(auto_on == 1'b0, "R7 no flush", auto_on, 0);
        fill(0, 4);
        step();
        fill_valid = 1'b0;
        step();
        fifo_flush = 1'b1;
        step();
        fifo_flush = 1'b0;
        repeat (3) step();
        chk(auto_on == 1'b0, "R7 pending blocks", auto_on, 0);
        chk(irq == 1'b1, "R7 still manual", irq, 1);
        cmd_strobe = 1'b1;
        cmd_skip   = 1'b1;
        step();
        cmd_strobe = 1'b0;
        cmd_skip   = 1'b0;
        step();
        step();
        chk(auto_on == 1'b1, "R7 armed", auto_on, 1);

        // R2 auto sweep with read on the commit edge
        for (int c = 1; c <= PMAX; c++) begin
            fill(c % NBUF, c);
            step();
            fill_valid = 1'b0;
            fifo_rd = 1'b1;
            step();
            fifo_rd = 1'b0;
            lvl = lvl + c - ((lvl > 0) ? 1 : 0);
            chk(commit_valid == 1'b1, "R2 auto commit", commit_valid, 1);
            chk(int'(commit_count) == c && int'(commit_idx) == c % NBUF, "R2 data",
                int'(commit_count), c);
            chk(irq == 1'b0, "R2 irq low", irq, 0);
            chk(int'(fifo_level) == lvl, "R3 level with read", int'(fifo_level), lvl);
            if (lvl > 20) drain();
        end
        drain();

        // R6 back-to-back in auto
        fill(1, 3); step();
        fill(2, 4); step();
        fill_valid = 1'b0;
        chk(commit_valid && commit_idx == 2'd1, "R6 auto first", int'(commit_idx), 1);
        step();
        chk(commit_valid && commit_idx == 2'd2, "R6 auto second", int'(commit_idx), 2);
        lvl = 7;
        drain();

        // R9 auto stall
        fill(0, 16); step();
        fill(1, 16); step();
        fill(2, 16); step();
        fill_valid = 1'b0;
        step();
        lvl = 32;
        chk(commit_valid == 1'b0, "R9 stall", commit_valid, 0);
        chk(int'(fifo_level) == lvl, "R9 stall level", int'(fifo_level), lvl);
        for (int k = 0; k < 8; k++) begin
            fifo_rd = 1'b1;
            step();
            lvl--;
            chk(commit_valid == 1'b0, "R9 still waiting", commit_valid, 0);
        end
        fifo_rd = 1'b0;
        step();
        lvl += 16;
        chk(commit_valid && commit_idx == 2'd2, "R9 stalled commit", int'(commit_idx), 2);
        chk(int'(fifo_level) == CAP, "R9 level at cap", int'(fifo_level), CAP);
        drain();

        // R10 flush collides with auto commit
        fill(1, 9);
        step();
        fill_valid = 1'b0;
        fifo_flush = 1'b1;
        step();
        fifo_flush = 1'b0;
        chk(commit_valid == 1'b0 && fifo_level == '0, "R10 blocked", commit_valid, 0);
        step();
        lvl = 9;
        chk(commit_valid == 1'b1 && int'(fifo_level) == 9, "R10 after flush",
            int'(fifo_level), 9);
        drain();

        // R7 dropping revision control returns to manual
        rev_en = 1'b0;
        step();
        chk(auto_on == 1'b0, "R7 rev drop", auto_on, 0);
        fill(3, 2);
        step();
        fill_valid = 1'b0;
        step();
        chk(irq == 1'b1 && commit_valid == 1'b0, "R7 manual again", irq, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule